// File: doc/BRIEF.md
# Single-Wire Bus Identifier Search Responder

This block is the device-side participant in an identifier search on a single-wire, open-drain, wired-AND bus. Each instance holds a fixed 64-bit identifier as a parameter. The physical slot timing is decoded elsewhere, so the block sees the bus as single-cycle slot events: a bus reset, a master write slot that carries the bit the master wrote, and a master read slot. It answers on one active-high pull-down output. The wire reads low whenever any attached device pulls it.

After a bus reset the responder takes in a command byte. If that byte is the search command, the responder walks through its identifier bit by bit. For each position it offers the bit, then the inverse of the bit, and then compares its bit with the one the master picked. A device whose bit differs from the pick goes silent until the next bus reset. The device that survives every position is the one the master has singled out, and it flags that on an output. Several instances on one wired-AND net let a master enumerate every identifier, one per pass.

Top module: `ow_search_responder`

## Requirements
- R1: In any cycle where `slot_reset_i` is high, `pull_low_o` is high in that same cycle (presence), whatever the state.
- R2: `pull_low_o` is high only in a cycle with `slot_reset_i` or `slot_read_i` high. A write slot alone never pulls the bus.
- R3: After a bus reset the next 8 write slots form a command, least significant bit first. Only the value 0xF0 starts a search. Any other value leaves the responder silent on read slots until the next bus reset.
- R4: During a search, identifier positions are visited from bit 0 up to bit 63. In the first read slot of a position the responder pulls low exactly when its bit at that position is 0.
- R5: In the second read slot of a position the responder pulls low exactly when its bit at that position is 1.
- R6: The write slot after the two read slots carries the master's pick. If the pick differs from the responder's bit, it releases the bus for every later slot until the next bus reset.
- R7: If the pick matches at position 63, `addressed_o` goes high after that write slot and stays high until the next bus reset. While it is high, read slots are not pulled.
- R8: A bus reset at any point abandons the current pass and clears `addressed_o` on the next cycle. If a read or write strobe falls in the same cycle as the reset, the reset wins and that strobe is ignored.
- R9: After `rst_n` and before the first bus reset, the responder is idle: read slots are not pulled and `addressed_o` is low.
- R10: Slots that arrive out of order in a search have no effect. A write slot during either read step is ignored, and a read slot while a pick is awaited is not pulled and does not advance the position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_reset_i | input | 1 | Single-cycle bus reset slot event |
| slot_read_i | input | 1 | Single-cycle master read slot event |
| slot_write_i | input | 1 | Single-cycle master write slot event |
| write_bit_i | input | 1 | Bit the master wrote, valid with `slot_write_i` |
| pull_low_o | output | 1 | Open-drain pull-down request, high pulls the wire low |
| addressed_o | output | 1 | High once this device survived a full search pass |

## Verification
A bus reset can coincide with a write slot or a read slot. The bench provokes this by raising a reset together with a write strobe partway through the command byte, and then sending a full fresh search command. It judges the result by whether the following search reads match the model: a shifted-in stray bit would corrupt the command and silence every device. The bench also checks that a reset in the middle of a pass clears the addressed flag and that a new pass then picks the intended device.

// File: rtl/ow_search_pkg.sv
package ow_search_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_SRCH = 2'd2,
        PH_ADDR = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_TRUE = 2'd0,
        ST_COMP = 2'd1,
        ST_PICK = 2'd2
    } step_e;

endpackage

// File: rtl/ow_id_mux.sv
module ow_id_mux #(
    parameter int ID_W = 64,
    parameter logic [ID_W-1:0] ROM_ID = '0,
    localparam int POS_W = $clog2(ID_W)
) (
    input  logic [POS_W-1:0] pos_i,
    output logic             bit_o
);

    logic [ID_W-1:0] id_vec;

    for (genvar g = 0; g < ID_W; g++) begin : g_bits
        assign id_vec[g] = ROM_ID[g];
    end

    assign bit_o = id_vec[pos_i];

endmodule

// File: rtl/ow_cmd_shift.sv
module ow_cmd_shift #(
    parameter int CMD_W = 8,
    parameter logic [CMD_W-1:0] MATCH = 8'hF0,
    localparam int CNT_W = $clog2(CMD_W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic last_o,
    output logic hit_o
);

    typedef struct packed {
        logic [CMD_W-1:0] sr;
        logic [CNT_W-1:0] cnt;
    } sh_t;

    sh_t sh_d, sh_q;
    logic [CMD_W-1:0] word;

    always_comb begin
        sh_d   = sh_q;
        last_o = (sh_q.cnt == CNT_W'(CMD_W - 1));
        word   = {bit_i, sh_q.sr[CMD_W-1:1]};
        hit_o  = (word == MATCH);
        if (clear_i) begin
            sh_d = '0;
        end else if (shift_i) begin
            sh_d.sr  = word;
            sh_d.cnt = last_o ? '0 : sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

endmodule

// File: rtl/ow_search_fsm.sv
module ow_search_fsm
    import ow_search_pkg::*;
#(
    parameter int ID_W = 64,
    localparam int POS_W = $clog2(ID_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_reset_i,
    input  logic             slot_read_i,
    input  logic             slot_write_i,
    input  logic             write_bit_i,
    input  logic             id_bit_i,
    input  logic             cmd_last_i,
    input  logic             cmd_hit_i,
    output logic             cmd_shift_o,
    output logic [POS_W-1:0] pos_o,
    output logic             pull_low_o,
    output logic             addressed_o
);

    typedef struct packed {
        phase_e           phase;
        step_e            step;
        logic [POS_W-1:0] pos;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        pull_low_o  = 1'b0;
        cmd_shift_o = 1'b0;
        if (slot_reset_i) begin
            pull_low_o = 1'b1;
            st_d.phase = PH_CMD;
            st_d.step  = ST_TRUE;
            st_d.pos   = '0;
        end else begin
            unique case (st_q.phase)
                PH_CMD: begin
                    if (slot_write_i) begin
                        cmd_shift_o = 1'b1;
                        if (cmd_last_i) begin
                            st_d.phase = cmd_hit_i ? PH_SRCH : PH_IDLE;
                            st_d.step  = ST_TRUE;
                            st_d.pos   = '0;
                        end
                    end
                end
                PH_SRCH: begin
                    if (slot_read_i) begin
                        unique case (st_q.step)
                            ST_TRUE: begin
                                pull_low_o = ~id_bit_i;
                                st_d.step  = ST_COMP;
                            end
                            ST_COMP: begin
                                pull_low_o = id_bit_i;
                                st_d.step  = ST_PICK;
                            end
                            default: ;
                        endcase
                    end else if (slot_write_i && st_q.step == ST_PICK) begin
                        if (write_bit_i != id_bit_i) begin
                            st_d.phase = PH_IDLE;
                        end else if (st_q.pos == POS_W'(ID_W - 1)) begin
                            st_d.phase = PH_ADDR;
                        end else begin
                            st_d.pos  = st_q.pos + 1'b1;
                            st_d.step = ST_TRUE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.step  <= ST_TRUE;
            st_q.pos   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o       = st_q.pos;
    assign addressed_o = (st_q.phase == PH_ADDR);

endmodule

// File: rtl/ow_search_responder.sv
module ow_search_responder #(
    parameter int ID_W = 64,
    parameter logic [ID_W-1:0] ROM_ID = 64'h0123_4567_89AB_CDEF,
    parameter int CMD_W = 8,
    parameter logic [CMD_W-1:0] SEARCH_CMD = 8'hF0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_reset_i,
    input  logic slot_read_i,
    input  logic slot_write_i,
    input  logic write_bit_i,
    output logic pull_low_o,
    output logic addressed_o
);

    localparam int POS_W = $clog2(ID_W);

    logic [POS_W-1:0] pos;
    logic id_bit, cmd_shift, cmd_last, cmd_hit;

    ow_id_mux #(.ID_W(ID_W), .ROM_ID(ROM_ID)) u_mux (
        .pos_i (pos),
        .bit_o (id_bit)
    );

    ow_cmd_shift #(.CMD_W(CMD_W), .MATCH(SEARCH_CMD)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (slot_reset_i),
        .shift_i (cmd_shift),
        .bit_i   (write_bit_i),
        .last_o  (cmd_last),
        .hit_o   (cmd_hit)
    );

    ow_search_fsm #(.ID_W(ID_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_reset_i (slot_reset_i),
        .slot_read_i  (slot_read_i),
        .slot_write_i (slot_write_i),
        .write_bit_i  (write_bit_i),
        .id_bit_i     (id_bit),
        .cmd_last_i   (cmd_last),
        .cmd_hit_i    (cmd_hit),
        .cmd_shift_o  (cmd_shift),
        .pos_o        (pos),
        .pull_low_o   (pull_low_o),
        .addressed_o  (addressed_o)
    );

endmodule

// File: rtl/ow_search_responder_chk.sv
module ow_search_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic slot_reset_i,
    input logic slot_read_i,
    input logic slot_write_i,
    input logic pull_low_o,
    input logic addressed_o
);

    assert_presence_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_reset_i |-> pull_low_o);

    assert_write_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_write_i && !slot_reset_i && !slot_read_i) |-> !pull_low_o);

    assert_drive_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low_o |-> (slot_reset_i || slot_read_i));

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addressed_o && !slot_reset_i) |=> addressed_o);

    assert_addr_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addressed_o) |-> $past(slot_write_i));

    assert_addr_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addressed_o && !slot_reset_i) |-> !pull_low_o);

    assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_reset_i |=> !addressed_o);

endmodule

bind ow_search_responder ow_search_responder_chk u_chk (.*);

// File: tb/tb_ow_search_responder.sv
module tb_ow_search_responder;

    localparam int N = 4;
    localparam logic [63:0] IDS [N] = '{
        64'hA5C3_0F1E_2D3C_4B28,
        64'hA5C3_0F1E_2D3C_4B2C,
        64'h1234_5678_9ABC_DEF0,
        64'hA5C3_0F1E_2D3C_4B29
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_rst = 1'b0, s_rd = 1'b0, s_wr = 1'b0, wbit = 1'b0;
    logic [N-1:0] pl, ad;
    logic bus;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign bus = ~|pl;

    ow_search_responder #(.ROM_ID(IDS[0])) dut (
        .clk(clk), .rst_n(rst_n), .slot_reset_i(s_rst), .slot_read_i(s_rd),
        .slot_write_i(s_wr), .write_bit_i(wbit), .pull_low_o(pl[0]), .addressed_o(ad[0]));
    ow_search_responder #(.ROM_ID(IDS[1])) u_peer1 (
        .clk(clk), .rst_n(rst_n), .slot_reset_i(s_rst), .slot_read_i(s_rd),
        .slot_write_i(s_wr), .write_bit_i(wbit), .pull_low_o(pl[1]), .addressed_o(ad[1]));
    ow_search_responder #(.ROM_ID(IDS[2])) u_peer2 (
        .clk(clk), .rst_n(rst_n), .slot_reset_i(s_rst), .slot_read_i(s_rd),
        .slot_write_i(s_wr), .write_bit_i(wbit), .pull_low_o(pl[2]), .addressed_o(ad[2]));
    ow_search_responder #(.ROM_ID(IDS[3])) u_peer3 (
        .clk(clk), .rst_n(rst_n), .slot_reset_i(s_rst), .slot_read_i(s_rd),
        .slot_write_i(s_wr), .write_bit_i(wbit), .pull_low_o(pl[3]), .addressed_o(ad[3]));

    // Reference model of the whole wired-AND population
    bit m_cmdph = 0, m_srch = 0, m_done = 0;
    int m_pos = 0, m_step = 0, m_cnt = 0;
    logic [7:0] m_cmd = '0;
    logic [N-1:0] m_act = '0;

    function automatic logic m_read();
        logic r = 1'b1;
        if (!m_srch || m_step == 2) return 1'b1;
        for (int k = 0; k < N; k++) begin
            if (m_act[k]) begin
                if (m_step == 0 && !IDS[k][m_pos]) r = 1'b0;
                if (m_step == 1 &&  IDS[k][m_pos]) r = 1'b0;
            end
        end
        return r;
    endfunction

    function automatic logic [N-1:0] m_addr();
        return m_done ? m_act : '0;
    endfunction

    task automatic m_reset();
        m_cmdph = 1; m_srch = 0; m_done = 0; m_cnt = 0; m_cmd = '0;
        m_act = '0; m_pos = 0; m_step = 0;
    endtask

    task automatic m_write(input logic b);
        if (m_cmdph) begin
            m_cmd = {b, m_cmd[7:1]};
            m_cnt++;
            if (m_cnt == 8) begin
                m_cmdph = 0;
                if (m_cmd == 8'hF0) begin m_srch = 1; m_act = '1; end
            end
        end else if (m_srch && m_step == 2) begin
            for (int k = 0; k < N; k++)
                if (m_act[k] && IDS[k][m_pos] != b) m_act[k] = 1'b0;
            if (m_pos == 63) begin m_srch = 0; m_done = 1; end
            else begin m_pos++; m_step = 0; end
        end
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic slot_reset();
        @(negedge clk); s_rst = 1'b1;
        #5 chk("R1 presence", 64'(bus), 64'(1'b0));
        @(posedge clk); #1 s_rst = 1'b0;
        m_reset();
    endtask

    task automatic reset_with_write(input logic b);
        @(negedge clk); s_rst = 1'b1; s_wr = 1'b1; wbit = b;
        #5 chk("R8 reset beats write presence", 64'(bus), 64'(1'b0));
        @(posedge clk); #1 s_rst = 1'b0; s_wr = 1'b0;
        m_reset();
    endtask

    task automatic slot_read(input string req, output logic v);
        logic e;
        @(negedge clk); s_rd = 1'b1;
        #5 v = bus; e = m_read();
        chk(req, 64'(v), 64'(e));
        @(posedge clk); #1 s_rd = 1'b0;
        if (m_srch && m_step < 2) m_step++;
    endtask

    task automatic slot_write(input logic b);
        @(negedge clk); s_wr = 1'b1; wbit = b;
        #5 chk("R2 write slot released", 64'(bus), 64'(1'b1));
        @(posedge clk); #1 s_wr = 1'b0;
        m_write(b);
    endtask

    task automatic send_cmd(input logic [7:0] c);
        for (int i = 0; i < 8; i++) slot_write(c[i]);
    endtask

    task automatic read_pair(output logic r1, output logic r2);
        slot_read("R4 true bit", r1);
        slot_read("R5 complement bit", r2);
    endtask

    task automatic chk_addr(input string req);
        #1 chk(req, 64'(ad), 64'(m_addr()));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic r1, r2, dir, v;
        logic [63:0] rom;
        logic [63:0] found [8];
        int nfound, last_disc, last_zero, dup, hit;
        int unsigned seed_init;
        seed_init = $urandom(32'h00C0_FFEE);

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: idle after reset, before any bus reset
        chk("R9 idle pull", 64'(bus), 64'(1'b1));
        chk("R9 idle addressed", 64'(ad), 64'(0));
        slot_read("R9 read before bus reset", v);
        chk("R9 no drive", 64'(v), 64'(1'b1));

        // R3: wrong command keeps everyone silent
        slot_reset();
        send_cmd(8'h33);
        read_pair(r1, r2);
        chk("R3 non-search command silent", 64'({r1, r2}), 64'(2'b11));

        // R10: stray slots during a search
        slot_reset();
        send_cmd(8'hF0);
        slot_write(1'b1);
        read_pair(r1, r2);
        slot_read("R10 read during pick step", v);
        chk("R10 pick step undriven", 64'(v), 64'(1'b1));
        slot_write(r1 == r2 ? 1'b0 : r1);
        read_pair(r1, r2);

        // R8: reset coinciding with a write inside the command byte
        slot_reset();
        slot_write(1'b0); slot_write(1'b0); slot_write(1'b0); slot_write(1'b0);
        reset_with_write(1'b1);
        send_cmd(8'hF0);
        read_pair(r1, r2);
        chk("R8 fresh command after reset", 64'(r1 & r2), 64'(0));

        // R8: mid-pass reset then select device 2
        slot_reset();
        send_cmd(8'hF0);
        for (int i = 0; i < 10; i++) begin
            read_pair(r1, r2);
            slot_write(IDS[2][i]);
        end
        slot_reset();
        chk_addr("R8 addressed cleared");
        send_cmd(8'hF0);
        for (int i = 0; i < 64; i++) begin
            read_pair(r1, r2);
            slot_write(IDS[2][i]);
        end
        chk_addr("R7 device 2 addressed");
        chk("R7 only device 2", 64'(ad), 64'(4'b0100));
        slot_read("R7 addressed read silent", v);
        slot_reset();
        chk_addr("R8 rearm clears addressed");

        // R4 R5 R6 R7: full enumeration
        nfound = 0;
        last_disc = -1;
        rom = '0;
        do begin
            slot_reset();
            send_cmd(8'hF0);
            last_zero = -1;
            for (int i = 0; i < 64; i++) begin
                read_pair(r1, r2);
                chk("R6 some device present", 64'(r1 & r2), 64'(0));
                if (r1 != r2) dir = r1;
                else if (i < last_disc) dir = rom[i];
                else if (i == last_disc) dir = 1'b1;
                else dir = 1'b0;
                if (r1 == r2 && dir == 1'b0) last_zero = i;
                rom[i] = dir;
                slot_write(dir);
            end
            chk_addr("R7 single survivor");
            chk("R7 one addressed", 64'($countones(ad)), 64'(1));
            hit = 0;
            for (int k = 0; k < N; k++) if (IDS[k] == rom) hit = 1;
            chk("R6 enumerated id is real", 64'(hit), 64'(1));
            dup = 0;
            for (int j = 0; j < nfound; j++) if (found[j] == rom) dup = 1;
            chk("R6 id enumerated once", 64'(dup), 64'(0));
            if (nfound < 8) found[nfound] = rom;
            nfound++;
            last_disc = last_zero;
        end while (last_disc >= 0 && nfound < 8);
        chk("R6 all ids enumerated", 64'(nfound), 64'(N));

        // Random passes with stray slots
        for (int p = 0; p < 24; p++) begin
            slot_reset();
            send_cmd(($urandom_range(0, 5) == 0) ? 8'($urandom_range(0, 255)) : 8'hF0);
            for (int i = 0; i < 64; i++) begin
                if ($urandom_range(0, 15) == 0) slot_write(1'($urandom_range(0, 1)));
                read_pair(r1, r2);
                if ($urandom_range(0, 15) == 0) slot_read("R10 random stray read", v);
                if (r1 != r2 && $urandom_range(0, 19) != 0) dir = r1;
                else dir = 1'($urandom_range(0, 1));
                slot_write(dir);
            end
            chk_addr("R6 R7 random pass outcome");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule